// File: doc/BRIEF.md
# DMA Interrupt Mask and Status Unit

This unit gathers the completion and fault events of a multi-channel DMA engine into three independent interrupt groups (transmit, receive and engine-level) and drives a single host interrupt line from them. Each group keeps a sticky raw status vector with one bit per channel and an enable mask. Software reads both the raw and the masked view over a simple 32-bit register bus.

Software never writes the mask directly. It sets enable bits through one address and clears them through another, writing a one at each bit to change, so two agents can enable and disable channels without a read-modify-write race. Event sources pulse their event input for one cycle. They later acknowledge the bit through a per-channel acknowledge input. The host interrupt is registered. An end-of-interrupt write forces it low for a programmable number of cycles, after which it rises again if any enabled event is still pending. This gives an edge-sensitive interrupt controller a fresh edge.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After reset every raw bit and every mask bit is 0, `irq_out` is 0, and every register reads 0.
- R2: A one-cycle pulse on bit i of `tx_done` or `rx_done` sets bit i of that group's raw register (transmit raw at 0x80, receive raw at 0xA0). The bit can be read in the next cycle and stays set until bit i of the matching acknowledge input is high. When an event and its acknowledge occur in the same cycle, the bit ends up set.
- R3: `host_err` sets bit 1 of the engine-level raw register at 0xB0, and `host_err_ack` clears it. Bit 0 of that register is never set.
- R4: A write to a mask-set address (0x88 transmit, 0xA8 receive, 0xB8 engine) sets each mask bit whose write-data bit is 1 and leaves every other mask bit unchanged.
- R5: A write to a mask-clear address (0x8C, 0xAC, 0xBC) clears each mask bit whose write-data bit is 1. Writing all ones clears the whole group's mask in one access.
- R6: The masked status address of each group (0x84, 0xA4, 0xB4) reads raw AND mask. The mask-set and mask-clear addresses both read the current mask. Unused upper data bits read 0.
- R7: `irq_out` is high in a cycle exactly when, one cycle earlier, at least one masked bit of any group was set and no end-of-interrupt gap was in force.
- R8: Any write to 0x94, whatever its data, holds `irq_out` low for EOI_GAP_CYC cycles starting in the next cycle. After that it follows R7 again, so it reasserts if masked bits are still pending.
- R9: Writes to raw and masked status addresses change no state.
- R10: A mask write to one group leaves the masks of the other two groups unchanged.
- R11: Reads of 0x94 and of any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte address, word aligned |
| reg_wr_en | input | 1 | Write strobe for the current address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the current address (combinational) |
| tx_done | input | NUM_CH | Per-channel transmit completion pulses |
| tx_done_ack | input | NUM_CH | Per-channel transmit status acknowledge |
| rx_done | input | NUM_CH | Per-channel receive completion pulses |
| rx_done_ack | input | NUM_CH | Per-channel receive status acknowledge |
| host_err | input | 1 | Engine host-error pulse |
| host_err_ack | input | 1 | Host-error status acknowledge |
| irq_out | output | 1 | Combined host interrupt line |

## Verification
The main function is driven with single-channel events, several channels at once across groups, and an event and its acknowledge on the same bit in the same cycle. Comparing these shows whether status is sticky, whether set wins over clear, and whether the groups stay apart. Mask changes use partial set and clear patterns and an all-ones clear. These separate true write-one semantics from direct overwrite. End-of-interrupt writes are issued while events are still pending, so the bench can tell a real re-arm gap from a line that never drops or never returns. A behavioural model is compared with the line and the read port in every cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int REG_AW = 8;
    localparam int GROUPS = 3;

    localparam int GRP_TX  = 0;
    localparam int GRP_RX  = 1;
    localparam int GRP_DMA = 2;

    localparam int HOST_ERR_BIT = 1;

    localparam logic [REG_AW-1:0] OFS_EOI = 8'h94;

    typedef enum logic [1:0] {
        REG_RAW    = 2'd0,
        REG_MASKED = 2'd1,
        REG_MSET   = 2'd2,
        REG_MCLR   = 2'd3
    } grp_reg_e;

    function automatic logic [REG_AW-1:0] grp_base(input int g);
        case (g)
            GRP_TX:  return 8'h80;
            GRP_RX:  return 8'hA0;
            default: return 8'hB0;
        endcase
    endfunction

    function automatic logic [REG_AW-1:0] grp_addr(input int g, input grp_reg_e r);
        return grp_base(g) | {4'h0, r, 2'b00};
    endfunction

endpackage

// File: rtl/irq_group.sv
module irq_group #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt,
    input  logic [WIDTH-1:0] ack,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] wbits,
    output logic [WIDTH-1:0] raw_o,
    output logic [WIDTH-1:0] mask_o
);

    typedef struct packed {
        logic [WIDTH-1:0] raw;
        logic [WIDTH-1:0] mask;
    } grp_state_t;

    grp_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // an event in the same cycle as its acknowledge wins
        st_d.raw = (st_q.raw & ~ack) | evt;
        if (set_we) begin
            st_d.mask = st_q.mask | wbits;
        end else if (clr_we) begin
            st_d.mask = st_q.mask & ~wbits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o  = st_q.raw;
    assign mask_o = st_q.mask;

endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_agg_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int DATA_W = 32
) (
    input  logic [REG_AW-1:0]             addr,
    input  logic                          wr_en,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [GROUPS-1:0][WIDTH-1:0]  grp_raw,
    input  logic [GROUPS-1:0][WIDTH-1:0]  grp_mask,
    output logic [GROUPS-1:0]             set_we,
    output logic [GROUPS-1:0]             clr_we,
    output logic [WIDTH-1:0]              wbits,
    output logic                          eoi_wr,
    output logic [DATA_W-1:0]             rdata
);

    logic [GROUPS-1:0][DATA_W-1:0] grp_rd;
    logic [GROUPS-1:0]             grp_hit;
    grp_reg_e                      sel;

    assign sel    = grp_reg_e'(addr[3:2]);
    assign wbits  = wdata[WIDTH-1:0];
    assign eoi_wr = wr_en && (addr == OFS_EOI);

    for (genvar g = 0; g < GROUPS; g++) begin : g_dec
        localparam logic [REG_AW-1:0] BASE = grp_base(g);

        assign grp_hit[g] = (addr[REG_AW-1:4] == BASE[REG_AW-1:4]) && (addr[1:0] == 2'b00);
        assign set_we[g]  = wr_en && grp_hit[g] && (sel == REG_MSET);
        assign clr_we[g]  = wr_en && grp_hit[g] && (sel == REG_MCLR);

        always_comb begin
            grp_rd[g] = '0;
            if (grp_hit[g]) begin
                case (sel)
                    REG_RAW:    grp_rd[g][WIDTH-1:0] = grp_raw[g];
                    REG_MASKED: grp_rd[g][WIDTH-1:0] = grp_raw[g] & grp_mask[g];
                    default:    grp_rd[g][WIDTH-1:0] = grp_mask[g];
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int g = 0; g < GROUPS; g++) begin
            rdata = rdata | grp_rd[g];
        end
    end

endmodule

// File: rtl/irq_line.sv
module irq_line #(
    parameter int EOI_GAP_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic eoi,
    output logic irq_o
);

    localparam int GAP_W = (EOI_GAP_CYC < 2) ? 1 : $clog2(EOI_GAP_CYC + 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(EOI_GAP_CYC - 1);

    typedef struct packed {
        logic             irq;
        logic [GAP_W-1:0] gap;
    } line_state_t;

    line_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = pend && !eoi && (st_q.gap == '0);
        if (eoi) begin
            st_d.gap = GAP_LOAD;
        end else if (st_q.gap != '0) begin
            st_d.gap = st_q.gap - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int DATA_W      = 32,
    parameter int EOI_GAP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] tx_done,
    input  logic [NUM_CH-1:0] tx_done_ack,
    input  logic [NUM_CH-1:0] rx_done,
    input  logic [NUM_CH-1:0] rx_done_ack,
    input  logic              host_err,
    input  logic              host_err_ack,
    output logic              irq_out
);

    logic [GROUPS-1:0][NUM_CH-1:0] grp_evt;
    logic [GROUPS-1:0][NUM_CH-1:0] grp_ack;
    logic [GROUPS-1:0][NUM_CH-1:0] grp_raw;
    logic [GROUPS-1:0][NUM_CH-1:0] grp_mask;
    logic [GROUPS-1:0]             set_we;
    logic [GROUPS-1:0]             clr_we;
    logic [NUM_CH-1:0]             wbits;
    logic                          eoi_wr;
    logic                          any_pend;

    always_comb begin
        grp_evt          = '0;
        grp_ack          = '0;
        grp_evt[GRP_TX]  = tx_done;
        grp_ack[GRP_TX]  = tx_done_ack;
        grp_evt[GRP_RX]  = rx_done;
        grp_ack[GRP_RX]  = rx_done_ack;
        grp_evt[GRP_DMA][HOST_ERR_BIT] = host_err;
        grp_ack[GRP_DMA][HOST_ERR_BIT] = host_err_ack;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        irq_group #(
            .WIDTH (NUM_CH)
        ) u_grp (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (grp_evt[g]),
            .ack    (grp_ack[g]),
            .set_we (set_we[g]),
            .clr_we (clr_we[g]),
            .wbits  (wbits),
            .raw_o  (grp_raw[g]),
            .mask_o (grp_mask[g])
        );
    end

    irq_reg_decode #(
        .WIDTH  (NUM_CH),
        .DATA_W (DATA_W)
    ) u_dec (
        .addr     (reg_addr),
        .wr_en    (reg_wr_en),
        .wdata    (reg_wdata),
        .grp_raw  (grp_raw),
        .grp_mask (grp_mask),
        .set_we   (set_we),
        .clr_we   (clr_we),
        .wbits    (wbits),
        .eoi_wr   (eoi_wr),
        .rdata    (reg_rdata)
    );

    assign any_pend = |(grp_raw & grp_mask);

    irq_line #(
        .EOI_GAP_CYC (EOI_GAP_CYC)
    ) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (any_pend),
        .eoi   (eoi_wr),
        .irq_o (irq_out)
    );

endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [7:0]                    reg_addr,
    input logic                          reg_wr_en,
    input logic [DATA_W-1:0]             reg_wdata,
    input logic [NUM_CH-1:0]             tx_done,
    input logic [NUM_CH-1:0]             tx_done_ack,
    input logic                          host_err,
    input logic [GROUPS-1:0][NUM_CH-1:0] grp_raw,
    input logic [GROUPS-1:0][NUM_CH-1:0] grp_mask,
    input logic                          any_pend,
    input logic                          irq_out
);

    logic wr_tx_set, wr_tx_clr, wr_tx_raw, wr_eoi;
    assign wr_tx_set = reg_wr_en && reg_addr == grp_addr(GRP_TX, REG_MSET);
    assign wr_tx_clr = reg_wr_en && reg_addr == grp_addr(GRP_TX, REG_MCLR);
    assign wr_tx_raw = reg_wr_en && reg_addr == grp_addr(GRP_TX, REG_RAW);
    assign wr_eoi    = reg_wr_en && reg_addr == OFS_EOI;

    p_evt_sets_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done != '0) |=> ((grp_raw[GRP_TX] & $past(tx_done)) == $past(tx_done)));

    p_ack_clears_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_done_ack & ~tx_done) != '0) |=> ((grp_raw[GRP_TX] & $past(tx_done_ack & ~tx_done)) == '0));

    p_host_err_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |=> grp_raw[GRP_DMA][HOST_ERR_BIT]);

    p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx_set |=> ((grp_mask[GRP_TX] & $past(reg_wdata[NUM_CH-1:0])) == $past(reg_wdata[NUM_CH-1:0])));

    p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx_clr |=> ((grp_mask[GRP_TX] & $past(reg_wdata[NUM_CH-1:0])) == '0));

    p_irq_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(any_pend));

    p_eoi_drops_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_eoi |=> !irq_out);

    p_raw_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx_raw && tx_done == '0 && tx_done_ack == '0) |=> $stable(grp_raw[GRP_TX]));

    p_other_mask_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx_set || wr_tx_clr) |=> ($stable(grp_mask[GRP_RX]) && $stable(grp_mask[GRP_DMA])));

endmodule

bind dma_irq_aggregator irq_agg_checker #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wr_en   (reg_wr_en),
    .reg_wdata   (reg_wdata),
    .tx_done     (tx_done),
    .tx_done_ack (tx_done_ack),
    .host_err    (host_err),
    .grp_raw     (grp_raw),
    .grp_mask    (grp_mask),
    .any_pend    (any_pend),
    .irq_out     (irq_out)
);

// File: tb/test_dma_irq_aggregator.sv
module test_dma_irq_aggregator;

    localparam int NCH = 8;
    localparam int DW  = 32;
    localparam int GAP = 2;
    localparam logic [31:0] CHM = (32'h1 << NCH) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    reg_addr = 8'h00;
    logic          reg_wr_en = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [NCH-1:0] tx_done = '0, tx_done_ack = '0, rx_done = '0, rx_done_ack = '0;
    logic          host_err = 1'b0, host_err_ack = 1'b0;
    logic          irq_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dma_irq_aggregator #(.NUM_CH(NCH), .DATA_W(DW), .EOI_GAP_CYC(GAP)) i_dma_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_done(tx_done),
        .tx_done_ack(tx_done_ack), .rx_done(rx_done), .rx_done_ack(rx_done_ack),
        .host_err(host_err), .host_err_ack(host_err_ack), .irq_out(irq_out)
    );

    // behavioural reference model, index 0 tx, 1 rx, 2 engine
    logic [31:0] m_raw [3];
    logic [31:0] m_mask [3];
    logic        m_irq;
    int          m_gap;

    always @(posedge clk) begin : model
        logic pend, eoi;
        logic [31:0] ev [3];
        logic [31:0] ak [3];
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin m_raw[k] = 0; m_mask[k] = 0; end
            m_irq = 0; m_gap = 0;
        end else begin
            pend = ((m_raw[0] & m_mask[0]) | (m_raw[1] & m_mask[1]) | (m_raw[2] & m_mask[2])) != 0;
            eoi  = reg_wr_en && reg_addr == 8'h94;
            m_irq = pend && !eoi && m_gap == 0;
            if (eoi) m_gap = GAP - 1; else if (m_gap > 0) m_gap = m_gap - 1;
            ev[0] = 32'(tx_done); ak[0] = 32'(tx_done_ack);
            ev[1] = 32'(rx_done); ak[1] = 32'(rx_done_ack);
            ev[2] = {30'd0, host_err, 1'b0}; ak[2] = {30'd0, host_err_ack, 1'b0};
            for (int k = 0; k < 3; k++) m_raw[k] = (m_raw[k] & ~ak[k]) | ev[k];
            if (reg_wr_en) begin
                case (reg_addr)
                    8'h88: m_mask[0] = m_mask[0] | (reg_wdata & CHM);
                    8'h8C: m_mask[0] = m_mask[0] & ~reg_wdata;
                    8'hA8: m_mask[1] = m_mask[1] | (reg_wdata & CHM);
                    8'hAC: m_mask[1] = m_mask[1] & ~reg_wdata;
                    8'hB8: m_mask[2] = m_mask[2] | (reg_wdata & CHM);
                    8'hBC: m_mask[2] = m_mask[2] & ~reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int k;
        if (a[7:4] == 4'h8) k = 0;
        else if (a[7:4] == 4'hA) k = 1;
        else if (a[7:4] == 4'hB) k = 2;
        else return 32'h0;
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[3:2])
            2'd0: return m_raw[k];
            2'd1: return m_raw[k] & m_mask[k];
            default: return m_mask[k];
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // advance one cycle and compare against the model away from the edge
    task automatic tick();
        @(negedge clk);
        cycles++;
        if (rst_n) begin
            check("R7 irq line vs model", 32'(irq_out), 32'(m_irq));
            check("R6 read port vs model", reg_rdata, model_read(reg_addr));
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        tick();
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        tick();
        check(req, reg_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog expired actual=%0d expected<%0d", 20000, 20000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        rd("R1 tx raw after reset", 8'h80, 32'h0);
        rd("R1 tx mask after reset", 8'h88, 32'h0);
        rd("R1 rx masked after reset", 8'hA4, 32'h0);
        rd("R1 engine mask after reset", 8'hBC, 32'h0);
        check("R1 irq after reset", 32'(irq_out), 32'h0);

        // R2 event on tx channel 3
        tx_done = 8'h08; tick(); tx_done = '0;
        rd("R2 tx raw ch3", 8'h80, 32'h08);
        rd("R6 masked with empty mask", 8'h84, 32'h0);
        check("R7 no irq while masked off", 32'(irq_out), 32'h0);

        // R4/R6/R7 enable ch2,ch3
        wr(8'h88, 32'h0C);
        rd("R4 tx mask after set", 8'h88, 32'h0C);
        check("R7 irq raised by enabled pending bit", 32'(irq_out), 32'h1);
        rd("R6 clear address reads mask", 8'h8C, 32'h0C);
        rd("R6 tx masked status", 8'h84, 32'h08);

        // R9 writes to status addresses ignored
        wr(8'h80, 32'hFF);
        wr(8'h84, 32'hFF);
        rd("R9 tx raw after status writes", 8'h80, 32'h08);
        rd("R9 tx mask after status writes", 8'h88, 32'h0C);

        // R8 end of interrupt with bit still pending
        wr(8'h94, 32'h0);
        check("R8 irq low after eoi", 32'(irq_out), 32'h0);
        tick();
        check("R8 irq still low in gap", 32'(irq_out), 32'h0);
        tick();
        check("R8 irq reasserts after gap", 32'(irq_out), 32'h1);

        // R10 receive group independent
        rx_done = 8'h81; tick(); rx_done = '0;
        wr(8'hA8, 32'h01);
        rd("R6 rx masked status", 8'hA4, 32'h01);
        rd("R10 tx mask untouched by rx write", 8'h88, 32'h0C);
        rd("R2 rx raw two channels", 8'hA0, 32'h81);

        // R2 acknowledge clears, same-cycle event beats acknowledge
        tx_done_ack = 8'h08; tick(); tx_done_ack = '0;
        rd("R2 tx raw cleared by ack", 8'h80, 32'h0);
        rx_done = 8'h20; rx_done_ack = 8'h20; tick(); rx_done = '0; rx_done_ack = '0;
        rd("R2 event wins over ack", 8'hA0, 32'hA1);

        // R3 host error
        host_err = 1'b1; tick(); host_err = 1'b0;
        rd("R3 host error bit 1", 8'hB0, 32'h02);
        wr(8'hB8, 32'hFF);
        rd("R3 host error masked", 8'hB4, 32'h02);
        host_err_ack = 1'b1; tick(); host_err_ack = 1'b0;
        rd("R3 host error acknowledged", 8'hB0, 32'h0);

        // R5 partial clear, then all-ones clear of every group
        wr(8'h8C, 32'h04);
        rd("R5 partial clear", 8'h88, 32'h08);
        wr(8'h8C, 32'hFFFF_FFFF);
        wr(8'hAC, 32'hFFFF_FFFF);
        wr(8'hBC, 32'hFFFF_FFFF);
        rd("R5 tx mask all cleared", 8'h88, 32'h0);
        rd("R5 rx mask all cleared", 8'hA8, 32'h0);
        rd("R5 engine mask all cleared", 8'hB8, 32'h0);
        check("R7 irq low with nothing enabled", 32'(irq_out), 32'h0);

        // R4 zero bits leave mask bits alone
        wr(8'h88, 32'h01);
        wr(8'h88, 32'h02);
        rd("R4 set keeps earlier bits", 8'h88, 32'h03);

        // R11 unmapped and eoi reads
        rd("R11 unmapped read", 8'h40, 32'h0);
        rd("R11 eoi address read", 8'h94, 32'h0);
        repeat (4) tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule